// File: doc/BRIEF.md
# Windowed bandwidth zone monitor

The block measures traffic on a monitored bus by summing a per-cycle transfer count, given in units of a configured block size, over fixed sampling windows. The window length is a number of ticks of a sampling-timer strobe. When a window closes, its total is compared with three programmable thresholds (low, medium, high) and placed in one of four zones. The zone that was hit selects a programmable action field, which can increment or clear the hit counter of each zone. A zone raises its status bit once its hit counter reaches a programmable hit count. The block also keeps, for each zone, the largest window total seen in that zone.

Software configures and services the block through a simple register port with a combinational read path. A local interrupt reports any enabled zone status bit. A gated global interrupt latches that condition and stays pending until software clears it while no enabled status bit remains set. Choosing new thresholds from the measured maxima is left to software.

Top module: `bw_zone_mon`

## Requirements
- R1: While the monitor is enabled and the window register (0x020) holds W != 0, a window closes on every W-th tick. Its total is the saturated sum of `beat_i` over the cycles since the previous close, including the closing cycle, and the next window starts empty. W = 0 never closes a window.
- R2: While the enable bit (0x010 bit 0) is 0, the tick counter and the accumulator are held at zero and no window closes, so traffic in that time reaches no zone.
- R3: A closing total T is placed in zone 0 if T <= low (0x02c), in zone 1 if low < T <= medium (0x028), in zone 2 if medium < T <= high (0x024), and otherwise in zone 3. A total equal to a threshold counts toward the lower zone.
- R4: The window accumulator saturates at 4095 instead of wrapping.
- R5: The action register (0x030) holds one 8-bit field per zone z at bits 8z+7..8z. Inside the field of the zone that was hit, the slot at bits 2k+1..2k acts on the hit counter of zone k: code 2 increments it, code 1 clears it, and codes 0 and 3 leave it unchanged.
- R6: Hit counters saturate at 255. An increment of zone k's counter sets status bit k when the new value is >= the hit count at bits 8k+7..8k of 0x034. A hit count of 0 never sets the status bit.
- R7: The register at 0x044 + 4z reads the largest total placed in zone z since the last full clear. It is updated when a window closes into zone z with a larger total.
- R8: Status (0x000, bits 3..0, one bit per zone) is sticky. Writing 1s to 0x008 clears the matching bits, and 0x008 reads as zero. A status set in the same cycle wins over a clear.
- R9: `irq_o` is high while any status bit is set whose bit in the interrupt enable register (0x00c, bits 3..0) is also set.
- R10: A global pending flag is set whenever `irq_o` is high. A write of bit 0 to 0x03c clears it only if `irq_o` is low, so clearing it while a local interrupt is still pending leaves it set. `gl_irq_o` is the flag gated by the global enable (0x038 bit 0).
- R11: A write to 0x014 with bit 0 set clears all hit counters. A write with bit 1 set also clears the zone maxima, the tick counter and the accumulator, and it cancels a window closing in the same cycle. A write with only bit 0 leaves the maxima unchanged. 0x014 reads as zero.
- R12: After reset every register reads zero and both interrupts are low. The window register (20 bits), the thresholds (12 bits), the action and hit-count registers (32 bits), 0x00c, 0x010 and 0x038 read back what was written. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| tick_i | input | 1 | Sampling-timer tick strobe |
| beat_i | input | 8 | Transfer count this cycle, in block units |
| irq_o | output | 1 | Local interrupt |
| gl_irq_o | output | 1 | Gated global interrupt |

## Verification
A wrong tick count or a wrong accumulator shows up at the close of the first window: the zone status bit or the zone maximum read back differs from the total W times the beat value, just one cycle after the close. A wrong action decode or a wrong counter value does not show at once. It only shows when the next hit of the affected zone fails to set status, or sets it too early. For that reason the bench spends several windows on hit-count two, on the clear actions and on the 256th hit at the saturation point. Global-flag errors show up on `gl_irq_o` one cycle after the local interrupt changes or a global clear is written.

// File: rtl/bwz_pkg.sv
package bwz_pkg;
  localparam int NZ    = 4;       // zones
  localparam int FLD_W = 2 * NZ;  // action field per zone
  localparam int DATA_W = 32;

  localparam int OFF_STAT  = 'h000;
  localparam int OFF_ICLR  = 'h008;
  localparam int OFF_IEN   = 'h00c;
  localparam int OFF_EN    = 'h010;
  localparam int OFF_CCLR  = 'h014;
  localparam int OFF_WIN   = 'h020;
  localparam int OFF_HI    = 'h024;
  localparam int OFF_MED   = 'h028;
  localparam int OFF_LO    = 'h02c;
  localparam int OFF_ACT   = 'h030;
  localparam int OFF_TCNT  = 'h034;
  localparam int OFF_GEN   = 'h038;
  localparam int OFF_GCLR  = 'h03c;
  localparam int OFF_MAX   = 'h044;

  localparam logic [1:0] ACT_CLR = 2'd1;
  localparam logic [1:0] ACT_INC = 2'd2;

  typedef logic [1:0] zone_t;
endpackage

// File: rtl/bwz_window.sv
module bwz_window
  import bwz_pkg::*;
#(
  parameter int WIN_W  = 20,
  parameter int CNT_W  = 12,
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [CNT_W-1:0]  thr_lo_i,
  input  logic [CNT_W-1:0]  thr_med_i,
  input  logic [CNT_W-1:0]  thr_hi_i,
  input  logic              clr_all_i,
  output logic              close_o,
  output zone_t             zone_o,
  output logic [CNT_W-1:0]  total_o
);
  localparam logic [CNT_W-1:0] ACC_MAX = '1;

  logic [WIN_W-1:0] timer_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W:0]   sum;
  logic             expire;

  assign sum     = {1'b0, acc_q} + (CNT_W+1)'(beat_i);
  assign total_o = sum[CNT_W] ? ACC_MAX : sum[CNT_W-1:0];
  assign expire  = en_i && tick_i && (win_i != '0) && (timer_q >= win_i - WIN_W'(1));
  assign close_o = expire && !clr_all_i;

  always_comb begin
    if (total_o > thr_hi_i)       zone_o = 2'd3;
    else if (total_o > thr_med_i) zone_o = 2'd2;
    else if (total_o > thr_lo_i)  zone_o = 2'd1;
    else                          zone_o = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      acc_q   <= '0;
    end else if (!en_i || clr_all_i || expire) begin
      timer_q <= '0;
      acc_q   <= '0;
    end else begin
      if (tick_i) timer_q <= timer_q + WIN_W'(1);
      acc_q <= total_o;
    end
  end

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0) && (timer_q == '0));

  assert_acc_mono_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !expire && !clr_all_i) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/bwz_zone.sv
module bwz_zone
  import bwz_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int HIT_W = 8,
  parameter int IDX   = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                close_i,
  input  zone_t               zone_i,
  input  logic [CNT_W-1:0]    total_i,
  input  logic [NZ*FLD_W-1:0] act_i,
  input  logic [HIT_W-1:0]    tcnt_i,
  input  logic                clr_cnt_i,
  input  logic                clr_all_i,
  output logic                hit_set_o,
  output logic [CNT_W-1:0]    max_o
);
  localparam logic [HIT_W-1:0] HIT_MAX = '1;

  logic [HIT_W-1:0] cnt_q, cnt_inc;
  logic [CNT_W-1:0] max_q;
  logic [1:0]       code;
  logic             inc, clr, wipe;

  assign code    = act_i[int'(zone_i)*FLD_W + 2*IDX +: 2];
  assign wipe    = clr_cnt_i || clr_all_i;
  assign inc     = close_i && (code == ACT_INC) && !wipe;
  assign clr     = close_i && (code == ACT_CLR);
  assign cnt_inc = (cnt_q == HIT_MAX) ? cnt_q : cnt_q + HIT_W'(1);
  assign hit_set_o = inc && (tcnt_i != '0) && (cnt_inc >= tcnt_i);
  assign max_o   = max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (wipe || clr) cnt_q <= '0;
    else if (inc)         cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        max_q <= '0;
    else if (clr_all_i) max_q <= '0;
    else if (close_i && (zone_i == zone_t'(IDX)) && (total_i > max_q))
      max_q <= total_i;
  end

  assert_hit_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !clr && cnt_q == HIT_MAX) |=> cnt_q == HIT_MAX);

  assert_clr_act_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);

  assert_max_mono_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_all_i |=> max_q >= $past(max_q));
endmodule

// File: rtl/bwz_regs.sv
module bwz_regs
  import bwz_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN_W  = 20,
  parameter int CNT_W  = 12,
  parameter int HIT_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  input  logic                       reg_we_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic [NZ-1:0]              hit_set_i,
  input  logic [NZ-1:0][CNT_W-1:0]   max_i,
  output logic                       en_o,
  output logic [WIN_W-1:0]           win_o,
  output logic [CNT_W-1:0]           thr_hi_o,
  output logic [CNT_W-1:0]           thr_med_o,
  output logic [CNT_W-1:0]           thr_lo_o,
  output logic [NZ*FLD_W-1:0]        act_o,
  output logic [NZ*HIT_W-1:0]        tcnt_o,
  output logic                       clr_cnt_o,
  output logic                       clr_all_o,
  output logic                       irq_o,
  output logic                       gl_irq_o
);
  logic [NZ-1:0] status_q, ien_q;
  logic          gen_q, gpend_q;
  logic w_iclr, w_ien, w_en, w_cclr, w_win, w_hi, w_med, w_lo, w_act, w_tcnt, w_gen, w_gclr;

  assign w_iclr = reg_we_i && reg_addr_i == ADDR_W'(OFF_ICLR);
  assign w_ien  = reg_we_i && reg_addr_i == ADDR_W'(OFF_IEN);
  assign w_en   = reg_we_i && reg_addr_i == ADDR_W'(OFF_EN);
  assign w_cclr = reg_we_i && reg_addr_i == ADDR_W'(OFF_CCLR);
  assign w_win  = reg_we_i && reg_addr_i == ADDR_W'(OFF_WIN);
  assign w_hi   = reg_we_i && reg_addr_i == ADDR_W'(OFF_HI);
  assign w_med  = reg_we_i && reg_addr_i == ADDR_W'(OFF_MED);
  assign w_lo   = reg_we_i && reg_addr_i == ADDR_W'(OFF_LO);
  assign w_act  = reg_we_i && reg_addr_i == ADDR_W'(OFF_ACT);
  assign w_tcnt = reg_we_i && reg_addr_i == ADDR_W'(OFF_TCNT);
  assign w_gen  = reg_we_i && reg_addr_i == ADDR_W'(OFF_GEN);
  assign w_gclr = reg_we_i && reg_addr_i == ADDR_W'(OFF_GCLR) && reg_wdata_i[0];

  assign clr_cnt_o = w_cclr && reg_wdata_i[0];
  assign clr_all_o = w_cclr && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0; win_o <= '0; thr_hi_o <= '0; thr_med_o <= '0; thr_lo_o <= '0;
      act_o <= '0; tcnt_o <= '0; ien_q <= '0; gen_q <= 1'b0;
    end else begin
      if (w_en)   en_o      <= reg_wdata_i[0];
      if (w_win)  win_o     <= reg_wdata_i[WIN_W-1:0];
      if (w_hi)   thr_hi_o  <= reg_wdata_i[CNT_W-1:0];
      if (w_med)  thr_med_o <= reg_wdata_i[CNT_W-1:0];
      if (w_lo)   thr_lo_o  <= reg_wdata_i[CNT_W-1:0];
      if (w_act)  act_o     <= reg_wdata_i[NZ*FLD_W-1:0];
      if (w_tcnt) tcnt_o    <= reg_wdata_i[NZ*HIT_W-1:0];
      if (w_ien)  ien_q     <= reg_wdata_i[NZ-1:0];
      if (w_gen)  gen_q     <= reg_wdata_i[0];
    end
  end

  // status: set wins over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else status_q <= (status_q & ~(w_iclr ? reg_wdata_i[NZ-1:0] : '0)) | hit_set_i;
  end

  assign irq_o = |(status_q & ien_q);

  // global flag re-arms while any enabled local bit is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gpend_q <= 1'b0;
    else if (irq_o)  gpend_q <= 1'b1;
    else if (w_gclr) gpend_q <= 1'b0;
  end

  assign gl_irq_o = gpend_q && gen_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(OFF_STAT): reg_rdata_o = DATA_W'(status_q);
      ADDR_W'(OFF_IEN):  reg_rdata_o = DATA_W'(ien_q);
      ADDR_W'(OFF_EN):   reg_rdata_o = DATA_W'(en_o);
      ADDR_W'(OFF_WIN):  reg_rdata_o = DATA_W'(win_o);
      ADDR_W'(OFF_HI):   reg_rdata_o = DATA_W'(thr_hi_o);
      ADDR_W'(OFF_MED):  reg_rdata_o = DATA_W'(thr_med_o);
      ADDR_W'(OFF_LO):   reg_rdata_o = DATA_W'(thr_lo_o);
      ADDR_W'(OFF_ACT):  reg_rdata_o = DATA_W'(act_o);
      ADDR_W'(OFF_TCNT): reg_rdata_o = DATA_W'(tcnt_o);
      ADDR_W'(OFF_GEN):  reg_rdata_o = DATA_W'(gen_q);
      default: begin
        for (int z = 0; z < NZ; z++)
          if (reg_addr_i == ADDR_W'(OFF_MAX + 4*z)) reg_rdata_o = DATA_W'(max_i[z]);
      end
    endcase
  end

  assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_iclr |=> (status_q & $past(status_q)) == $past(status_q));

  assert_gl_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gpend_q) |-> ($past(w_gclr) && !$past(irq_o)));
endmodule

// File: rtl/bw_zone_mon.sv
module bw_zone_mon
  import bwz_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN_W  = 20,
  parameter int CNT_W  = 12,
  parameter int BEAT_W = 8,
  parameter int HIT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tick_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              irq_o,
  output logic              gl_irq_o
);
  logic                     en, clr_cnt, clr_all, close;
  logic [WIN_W-1:0]         win;
  logic [CNT_W-1:0]         thr_hi, thr_med, thr_lo, total;
  logic [NZ*FLD_W-1:0]      act;
  logic [NZ*HIT_W-1:0]      tcnt;
  logic [NZ-1:0]            hit_set;
  logic [NZ-1:0][CNT_W-1:0] zmax;
  zone_t                    zone;

  bwz_regs #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .HIT_W(HIT_W)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wdata_i, .reg_we_i, .reg_rdata_o,
    .hit_set_i(hit_set), .max_i(zmax), .en_o(en), .win_o(win),
    .thr_hi_o(thr_hi), .thr_med_o(thr_med), .thr_lo_o(thr_lo),
    .act_o(act), .tcnt_o(tcnt), .clr_cnt_o(clr_cnt), .clr_all_o(clr_all),
    .irq_o, .gl_irq_o
  );

  bwz_window #(.WIN_W(WIN_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_win (
    .clk_i, .rst_ni, .en_i(en), .tick_i, .beat_i, .win_i(win),
    .thr_lo_i(thr_lo), .thr_med_i(thr_med), .thr_hi_i(thr_hi),
    .clr_all_i(clr_all), .close_o(close), .zone_o(zone), .total_o(total)
  );

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    bwz_zone #(.CNT_W(CNT_W), .HIT_W(HIT_W), .IDX(z)) u_zone (
      .clk_i, .rst_ni, .close_i(close), .zone_i(zone), .total_i(total),
      .act_i(act), .tcnt_i(tcnt[z*HIT_W +: HIT_W]),
      .clr_cnt_i(clr_cnt), .clr_all_i(clr_all),
      .hit_set_o(hit_set[z]), .max_o(zmax[z])
    );
  end

  assert_one_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_set));
endmodule

// File: tb/test_bw_zone_mon.sv
module test_bw_zone_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        tick = 1'b1;
  logic [7:0]  beat = '0;
  logic        irq, gl_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bw_zone_mon i_bw_zone_mon (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .tick_i(tick), .beat_i(beat),
    .irq_o(irq), .gl_irq_o(gl_irq)
  );

  localparam logic [7:0] A_STAT = 8'h00, A_ICLR = 8'h08, A_IEN = 8'h0c, A_EN = 8'h10,
    A_CCLR = 8'h14, A_WIN = 8'h20, A_HI = 8'h24, A_MED = 8'h28, A_LO = 8'h2c,
    A_ACT = 8'h30, A_TCNT = 8'h34, A_GEN = 8'h38, A_GCLR = 8'h3c, A_MAX = 8'h44;
  localparam int W = 8;
  localparam logic [31:0] ACT_SELF = 32'h8020_0802; // each zone increments itself
  localparam int NV = 9;
  localparam logic [7:0] VB [NV] = '{8'd5, 8'd13, 8'd25, 8'd26, 8'd37, 8'd38, 8'd12, 8'd0, 8'd255};
  localparam logic [1:0] VZ [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd0, 2'd3};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // tasks start in the low clock phase
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chkr(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic one_window(input logic [7:0] b, input int len);
    beat = b;
    wr(A_EN, 1);
    repeat (len) @(posedge clk);
    @(negedge clk);
    beat = '0;
    wr(A_EN, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chkr("R12 reset status", A_STAT, 0);
    chkr("R12 reset window", A_WIN, 0);
    chkr("R12 reset actions", A_ACT, 0);
    chkr("R12 reset max0", A_MAX, 0);
    chk("R12 reset irq", {30'd0, gl_irq, irq}, 0);

    wr(A_WIN, W); wr(A_LO, 100); wr(A_MED, 200); wr(A_HI, 300);
    wr(A_ACT, ACT_SELF); wr(A_TCNT, 32'h0101_0101); wr(A_IEN, 32'hf);
    chkr("R12 window readback", A_WIN, W);
    chkr("R12 high readback", A_HI, 300);
    chkr("R12 actions readback", A_ACT, ACT_SELF);
    chkr("R12 counts readback", A_TCNT, 32'h0101_0101);
    chkr("R12 ien readback", A_IEN, 32'hf);
    chkr("R11 clear reads zero", A_CCLR, 0);
    chkr("R12 unmapped", 8'hf0, 0);

    // R1 R3 R7: vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CCLR, 3); wr(A_ICLR, 32'hf);
      one_window(VB[i], W);
      chkr($sformatf("R3 zone vec%0d", i), A_STAT, 32'(1) << VZ[i]);
      chkr($sformatf("R1 total vec%0d", i), A_MAX + 8'(4*VZ[i]), 32'(W) * 32'(VB[i]));
    end

    // R9 enable gating
    chk("R9 irq pending", {31'd0, irq}, 1);
    wr(A_IEN, 32'h7);
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(A_IEN, 32'hf);
    chk("R9 irq unmasked", {31'd0, irq}, 1);

    // R10 global interrupt
    chk("R10 global gated off", {31'd0, gl_irq}, 0);
    wr(A_GEN, 1);
    chk("R10 global on", {31'd0, gl_irq}, 1);
    wr(A_GCLR, 1);
    chk("R10 global re-asserts", {31'd0, gl_irq}, 1);
    wr(A_ICLR, 32'hf);
    chk("R10 local cleared", {31'd0, irq}, 0);
    chk("R10 global still pending", {31'd0, gl_irq}, 1);
    wr(A_GCLR, 1);
    chk("R10 global cleared", {31'd0, gl_irq}, 0);
    wr(A_GEN, 0);

    // R8 partial write-1-to-clear
    wr(A_CCLR, 3);
    one_window(13, W); one_window(38, W);
    chkr("R8 two bits", A_STAT, 32'ha);
    wr(A_ICLR, 32'h8);
    chkr("R8 partial clear", A_STAT, 32'h2);
    chkr("R8 clear reads zero", A_ICLR, 0);

    // R6 hit count of two
    wr(A_CCLR, 3); wr(A_ICLR, 32'hf); wr(A_TCNT, 32'h0101_0201);
    one_window(13, W);
    chkr("R6 one of two hits", A_STAT, 0);
    one_window(13, W);
    chkr("R6 second hit fires", A_STAT, 32'h2);

    // R5 zone 3 clears zone 1 counter
    wr(A_ICLR, 32'hf); wr(A_CCLR, 1); wr(A_ACT, 32'h8420_0802);
    one_window(13, W); one_window(38, W); one_window(13, W);
    chkr("R5 clear action", A_STAT, 32'h8);
    wr(A_ACT, ACT_SELF);

    // R11 counter-only clear keeps maxima
    wr(A_CCLR, 3); wr(A_ICLR, 32'hf);
    one_window(13, W);
    wr(A_CCLR, 1);
    one_window(13, W);
    chkr("R11 counters cleared", A_STAT, 0);
    chkr("R11 max kept", A_MAX + 8'd4, 104);
    // R7 max only grows
    one_window(20, W); one_window(14, W);
    chkr("R7 max holds larger", A_MAX + 8'd4, 160);
    wr(A_CCLR, 2);
    chkr("R11 full clear max", A_MAX + 8'd4, 0);

    // R6 zero hit count never fires
    wr(A_ICLR, 32'hf); wr(A_TCNT, 32'h0101_0001);
    one_window(13, W); one_window(13, W);
    chkr("R6 zero count", A_STAT, 0);
    wr(A_TCNT, 32'h0101_0101);

    // R2 disabled: no windows, accumulator stays empty
    wr(A_CCLR, 3); wr(A_ICLR, 32'hf);
    beat = 200;
    repeat (40) @(negedge clk);
    chkr("R2 no close when off", A_STAT, 0);
    one_window(13, W);
    chkr("R2 clean restart", A_MAX + 8'd4, 104);

    // R1 zero window never closes
    wr(A_WIN, 0); wr(A_CCLR, 3); wr(A_ICLR, 32'hf);
    beat = 255;
    wr(A_EN, 1);
    repeat (40) @(negedge clk);
    chkr("R1 zero window", A_STAT, 0);
    beat = 0;
    wr(A_EN, 0);

    // R4 accumulator saturation
    wr(A_WIN, 20); wr(A_CCLR, 3);
    one_window(255, 20);
    chkr("R4 saturated total", A_MAX + 8'd12, 4095);

    // R6 hit counter saturation at 255
    wr(A_WIN, 2); wr(A_CCLR, 3); wr(A_ICLR, 32'hf); wr(A_TCNT, 32'h0101_ff01);
    beat = 60;
    wr(A_EN, 1);
    repeat (2*254) @(posedge clk);
    @(negedge clk);
    chkr("R6 254 hits", A_STAT, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chkr("R6 255th hit", A_STAT, 32'h2);
    wr(A_ICLR, 32'hf);
    @(posedge clk);
    @(negedge clk);
    chkr("R6 saturated refire", A_STAT, 32'h2);
    beat = 0;
    wr(A_EN, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule